// File: doc/BRIEF.md
# Rate and Burst Float Encoder

This block converts a requested committed rate, given in bits per second, and a burst size, given in bytes, into the compact pseudo-float fields that a token-bucket meter consumes. Each field set has the form (1 + M/256) · 2^E. The rate side also carries a clock-divider count that stretches the refill period when the rate is too low for the mantissa window. Only integer shifts, compares and one constant division are used.

A single-cycle `start` pulse captures a 64-bit rate and a 32-bit burst. The burst is encoded with a priority encoder. The rate is scaled by 64 and then normalised one shift per clock into the window [256,000,000, 512,000,000). A low value is doubled, and each doubling adds one to the divider. A high value is halved, and each halving adds one to the exponent. When normalisation ends, all five output fields update together and `done` pulses for one cycle. The fields then hold until the next accepted request completes.

Top module: `tbkt_float_enc`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `done` and all five output fields read zero until the first request completes.
- R2: The burst exponent is floor(log2(burst)); a burst of zero encodes as exponent 0, mantissa 0.
- R3: A burst below 256 gives a burst mantissa of 0 and leaves its exponent unclamped (0 to 7).
- R4: For 256 ≤ burst < 2^23 the burst mantissa is (burst − 2^E) / 2^(E−8), truncated, with E the burst exponent.
- R5: A burst of 2^23 or more clamps the burst exponent to 22 and saturates the burst mantissa to 255.
- R6: The rate is multiplied by 64 to give S. If 256,000,000 ≤ S < 512,000,000, the block outputs divider 0, exponent 0 and rate mantissa (S − 256,000,000) / 1,000,000.
- R7: If S is below the window, S is doubled until it enters the window. Each doubling adds 1 to the divider, and the rate exponent stays 0.
- R8: If S is at or above 512,000,000, S is halved until it falls below that bound. Each halving adds 1 to the rate exponent, and the divider stays 0.
- R9: The rate exponent never exceeds 22. If S is still at or above 512,000,000 at exponent 22, the rate mantissa saturates to 255.
- R10: The divider stops at 15, so a zero rate terminates. If S is still below the window at divider 15, the rate mantissa is 0.
- R11: `busy` rises the cycle after a start is accepted. When n shifts are needed, `done` is a one-cycle pulse on the (n+1)-th clock edge after acceptance, and `busy` falls on that same edge.
- R12: A start while `busy` is high is ignored. The output fields change only on a `done` cycle. A start in the `done` cycle itself is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse; captures rate_bps and burst_bytes when idle |
| rate_bps | input | 64 | Requested committed rate in bits per second |
| burst_bytes | input | 32 | Requested burst size in bytes |
| busy | output | 1 | Normalisation in progress |
| done | output | 1 | One-cycle completion pulse |
| rate_mant | output | 8 | Rate mantissa |
| rate_exp | output | 5 | Rate exponent (0 to 22) |
| rate_div | output | 4 | Rate clock-divider count (0 to 15) |
| burst_mant | output | 8 | Burst mantissa |
| burst_exp | output | 5 | Burst exponent (0 to 22) |

## Verification
Two events can fall in the same cycle: a new `start` and the completion of the previous request. Completion frees the block for a new request, so the timing decides whether that start is taken. The bench provokes this in two ways. It pulses `start` in the middle of a long zero-rate run, and it then holds `start` high across several runs so that each new request coincides with the previous completion. A behavioural model accepts a request only when it is itself idle and predicts `busy`, `done` and every field on every clock. An ignored request must leave the zero-rate result on the outputs. A request in the `done` cycle must begin a new run without losing a cycle.

// File: rtl/tbkt_float_pkg.sv
package tbkt_float_pkg;
   typedef enum logic [0:0] {
      NS_IDLE = 1'b0,
      NS_RUN  = 1'b1
   } norm_state_t;
endpackage

// File: rtl/tbkt_burst_enc.sv
module tbkt_burst_enc #(
   parameter int BURST_W = 32,
   parameter int MANT_W  = 8,
   parameter int EXP_MAX = 22,
   parameter int EXP_W   = 5
) (
   input  logic [BURST_W-1:0] burst,
   output logic [EXP_W-1:0]   exp_o,
   output logic [MANT_W-1:0]  mant_o
);
   localparam int MANT_MAX = (2 ** MANT_W) - 1;

   int                 msb;
   logic [BURST_W-1:0] rem;
   logic [BURST_W-1:0] sh;

   // leading-one position of the burst
   always_comb begin
      msb = 0;
      for (int i = 0; i < BURST_W; i++) begin
         if (burst[i]) msb = i;
      end
   end

   always_comb begin
      rem    = '0;
      sh     = '0;
      exp_o  = '0;
      mant_o = '0;
      if (msb < MANT_W) begin
         exp_o  = EXP_W'(msb);
         mant_o = '0;
      end else if (msb > EXP_MAX) begin
         exp_o  = EXP_W'(EXP_MAX);
         mant_o = '1;
      end else begin
         exp_o  = EXP_W'(msb);
         rem    = burst & ~(BURST_W'(1) << msb);
         sh     = rem >> (msb - MANT_W);
         mant_o = (sh > BURST_W'(MANT_MAX)) ? '1 : sh[MANT_W-1:0];
      end
   end
endmodule

// File: rtl/tbkt_rate_norm.sv
module tbkt_rate_norm
   import tbkt_float_pkg::*;
#(
   parameter int              RATE_W   = 64,
   parameter int              SCALE_SH = 6,
   parameter int              EXP_MAX  = 22,
   parameter int              EXP_W    = 5,
   parameter int              DIV_W    = 4,
   parameter longint unsigned WIN_LO   = 64'd256_000_000,
   parameter longint unsigned WIN_HI   = 64'd512_000_000,
   localparam int             TW       = RATE_W + SCALE_SH
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [RATE_W-1:0] rate,
   output logic              busy,
   output logic              fin,
   output logic              sat_lo,
   output logic [TW-1:0]     tmp,
   output logic [EXP_W-1:0]  exp_o,
   output logic [DIV_W-1:0]  div_o
);
   norm_state_t       st_q;
   logic [TW-1:0]     tmp_q;
   logic [EXP_W-1:0]  exp_q;
   logic [DIV_W-1:0]  div_q;
   logic              below;
   logic              above;
   logic              run;

   assign run   = (st_q == NS_RUN);
   assign below = tmp_q < TW'(WIN_LO);
   assign above = tmp_q >= TW'(WIN_HI);

   // stop when inside the window or when the relevant counter is exhausted
   assign fin = run && ((below && (div_q == '1)) ||
                        (above && (exp_q == EXP_W'(EXP_MAX))) ||
                        (!below && !above));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= NS_IDLE;
         tmp_q <= '0;
         exp_q <= '0;
         div_q <= '0;
      end else if (!run) begin
         if (load) begin
            st_q  <= NS_RUN;
            tmp_q <= {rate, SCALE_SH'(0)};
            exp_q <= '0;
            div_q <= '0;
         end
      end else if (fin) begin
         st_q <= NS_IDLE;
      end else if (below) begin
         tmp_q <= tmp_q << 1;
         div_q <= div_q + 1'b1;
      end else begin
         tmp_q <= tmp_q >> 1;
         exp_q <= exp_q + 1'b1;
      end
   end

   assign busy   = run;
   assign sat_lo = below;
   assign tmp    = tmp_q;
   assign exp_o  = exp_q;
   assign div_o  = div_q;
endmodule

// File: rtl/tbkt_rate_mant.sv
module tbkt_rate_mant #(
   parameter int              TW       = 70,
   parameter int              MANT_W   = 8,
   parameter longint unsigned WIN_LO   = 64'd256_000_000,
   parameter longint unsigned WIN_STEP = 64'd1_000_000
) (
   input  logic [TW-1:0]     tmp,
   input  logic              sat_lo,
   output logic [MANT_W-1:0] mant
);
   localparam int MANT_MAX = (2 ** MANT_W) - 1;

   logic [TW-1:0] q;

   assign q = (tmp - TW'(WIN_LO)) / TW'(WIN_STEP);

   // above the window the quotient overflows and saturates
   always_comb begin
      if (sat_lo)                 mant = '0;
      else if (q > TW'(MANT_MAX)) mant = '1;
      else                        mant = q[MANT_W-1:0];
   end
endmodule

// File: rtl/tbkt_float_enc.sv
module tbkt_float_enc #(
   parameter int              RATE_W   = 64,
   parameter int              BURST_W  = 32,
   parameter int              SCALE_SH = 6,
   parameter int              MANT_W   = 8,
   parameter int              EXP_MAX  = 22,
   parameter int              DIV_W    = 4,
   parameter longint unsigned WIN_LO   = 64'd256_000_000,
   parameter longint unsigned WIN_STEP = 64'd1_000_000,
   localparam int             EXP_W    = $clog2(EXP_MAX + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [RATE_W-1:0]  rate_bps,
   input  logic [BURST_W-1:0] burst_bytes,
   output logic               busy,
   output logic               done,
   output logic [MANT_W-1:0]  rate_mant,
   output logic [EXP_W-1:0]   rate_exp,
   output logic [DIV_W-1:0]   rate_div,
   output logic [MANT_W-1:0]  burst_mant,
   output logic [EXP_W-1:0]   burst_exp
);
   localparam int              TW     = RATE_W + SCALE_SH;
   localparam longint unsigned WIN_HI = WIN_LO + (64'd1 << MANT_W) * WIN_STEP;

   generate
      if (EXP_MAX >= BURST_W) begin : g_bad_exp
         $error("EXP_MAX must be below BURST_W");
      end
      if (MANT_W >= EXP_MAX) begin : g_bad_mant
         $error("MANT_W must be below EXP_MAX");
      end
      if (WIN_LO == 0 || WIN_STEP == 0) begin : g_bad_win
         $error("window bounds must be nonzero");
      end
   endgenerate

   logic               accept;
   logic               fin;
   logic               sat_lo;
   logic [TW-1:0]      tmp;
   logic [EXP_W-1:0]   n_exp;
   logic [DIV_W-1:0]   n_div;
   logic [MANT_W-1:0]  n_mant;
   logic [BURST_W-1:0] burst_q;
   logic [EXP_W-1:0]   b_exp;
   logic [MANT_W-1:0]  b_mant;

   assign accept = start && !busy;

   tbkt_rate_norm #(
      .RATE_W(RATE_W), .SCALE_SH(SCALE_SH), .EXP_MAX(EXP_MAX), .EXP_W(EXP_W),
      .DIV_W(DIV_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
   ) u_norm (
      .clk(clk), .rst_n(rst_n), .load(start), .rate(rate_bps),
      .busy(busy), .fin(fin), .sat_lo(sat_lo), .tmp(tmp),
      .exp_o(n_exp), .div_o(n_div)
   );

   tbkt_rate_mant #(
      .TW(TW), .MANT_W(MANT_W), .WIN_LO(WIN_LO), .WIN_STEP(WIN_STEP)
   ) u_rmant (
      .tmp(tmp), .sat_lo(sat_lo), .mant(n_mant)
   );

   tbkt_burst_enc #(
      .BURST_W(BURST_W), .MANT_W(MANT_W), .EXP_MAX(EXP_MAX), .EXP_W(EXP_W)
   ) u_benc (
      .burst(burst_q), .exp_o(b_exp), .mant_o(b_mant)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         burst_q <= '0;
      end else if (accept) begin
         burst_q <= burst_bytes;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done       <= 1'b0;
         rate_mant  <= '0;
         rate_exp   <= '0;
         rate_div   <= '0;
         burst_mant <= '0;
         burst_exp  <= '0;
      end else begin
         done <= fin;
         if (fin) begin
            rate_mant  <= n_mant;
            rate_exp   <= n_exp;
            rate_div   <= n_div;
            burst_mant <= b_mant;
            burst_exp  <= b_exp;
         end
      end
   end
endmodule

// File: rtl/tbkt_float_enc_chk.sv
module tbkt_float_enc_chk #(
   parameter int MANT_W  = 8,
   parameter int EXP_W   = 5,
   parameter int DIV_W   = 4,
   parameter int EXP_MAX = 22
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic [MANT_W-1:0] rate_mant,
   input logic [EXP_W-1:0]  rate_exp,
   input logic [DIV_W-1:0]  rate_div,
   input logic [MANT_W-1:0] burst_mant,
   input logic [EXP_W-1:0]  burst_exp
);
   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R11
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   // R12
   hold_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable({rate_mant, rate_exp, rate_div, burst_mant, burst_exp}));

   // R9
   exp_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (rate_exp <= EXP_W'(EXP_MAX)) && (burst_exp <= EXP_W'(EXP_MAX)));

   // R7
   div_no_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (rate_div != '0)) |-> (rate_exp == '0));

   // R3
   small_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (burst_exp < EXP_W'(MANT_W))) |-> (burst_mant == '0));
endmodule

bind tbkt_float_enc tbkt_float_enc_chk #(
   .MANT_W(MANT_W), .EXP_W(EXP_W), .DIV_W(DIV_W), .EXP_MAX(EXP_MAX)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .rate_mant(rate_mant), .rate_exp(rate_exp), .rate_div(rate_div),
   .burst_mant(burst_mant), .burst_exp(burst_exp)
);

// File: tb/tbkt_float_enc_bench.sv
`timescale 1ns/1ps
module tbkt_float_enc_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [63:0] rate_bps = '0;
   logic [31:0] burst_bytes = '0;
   logic        busy, done;
   logic [7:0]  rate_mant, burst_mant;
   logic [4:0]  rate_exp, burst_exp;
   logic [3:0]  rate_div;

   always #2.5 clk = ~clk;

   tbkt_float_enc u_tbkt_float_enc (
      .clk(clk), .rst_n(rst_n), .start(start), .rate_bps(rate_bps),
      .burst_bytes(burst_bytes), .busy(busy), .done(done),
      .rate_mant(rate_mant), .rate_exp(rate_exp), .rate_div(rate_div),
      .burst_mant(burst_mant), .burst_exp(burst_exp)
   );

   int    n_cmp = 0;
   int    n_bad = 0;
   int    cycles = 0;
   string cur_tag = "R1";
   bit    finished = 0;

   // reference model state
   bit          m_busy = 0, m_done = 0;
   int          m_cnt = 0;
   logic [7:0]  p_rm, p_bm, m_rm = 0, m_bm = 0;
   logic [4:0]  p_re, p_be, m_re = 0, m_be = 0;
   logic [3:0]  p_rd, m_rd = 0;
   int          p_n;

   task automatic rate_model(input logic [63:0] r);
      logic [71:0] s;
      s = {8'd0, r} * 72'd64;
      p_re = 0; p_rd = 0; p_n = 0;
      if (s < 72'd256_000_000) begin
         while (s < 72'd256_000_000 && p_rd < 15) begin
            s = s * 2; p_rd = p_rd + 1; p_n++;
         end
         p_rm = (s < 72'd256_000_000) ? 8'd0 : 8'((s - 72'd256_000_000) / 72'd1_000_000);
      end else begin
         while (s >= 72'd512_000_000 && p_re < 22) begin
            s = s / 2; p_re = p_re + 1; p_n++;
         end
         p_rm = (s >= 72'd512_000_000) ? 8'd255 : 8'((s - 72'd256_000_000) / 72'd1_000_000);
      end
   endtask

   task automatic burst_model(input logic [31:0] b);
      longint unsigned v, k;
      v = b; k = 0;
      while (v >= 2) begin v = v / 2; k++; end
      if (k < 8) begin
         p_be = 5'(k); p_bm = 0;
      end else if (k > 22) begin
         p_be = 22; p_bm = 255;
      end else begin
         p_be = 5'(k);
         p_bm = 8'((longint'(b) - (longint'(1) << k)) / (longint'(1) << (k - 8)));
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_done = 0; m_cnt = 0;
      end else begin
         m_done = 0;
         if (!m_busy) begin
            if (start) begin
               rate_model(rate_bps);
               burst_model(burst_bytes);
               m_cnt = p_n + 1;
               m_busy = 1;
            end
         end else begin
            m_cnt--;
            if (m_cnt == 0) begin
               m_busy = 0; m_done = 1;
               m_rm = p_rm; m_re = p_re; m_rd = p_rd; m_bm = p_bm; m_be = p_be;
            end
         end
      end
   end

   task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", cur_tag, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk("R11 done", 64'(done), 64'(m_done));
         chk("R11 busy", 64'(busy), 64'(m_busy));
         chk("R6 R8 R9 R10 rate_mant", 64'(rate_mant), 64'(m_rm));
         chk("R8 R9 rate_exp", 64'(rate_exp), 64'(m_re));
         chk("R7 R10 rate_div", 64'(rate_div), 64'(m_rd));
         chk("R3 R4 R5 burst_mant", 64'(burst_mant), 64'(m_bm));
         chk("R2 R5 burst_exp", 64'(burst_exp), 64'(m_be));
      end
   end

   // watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !finished) begin
         finished = 1;
         n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   task automatic wait_idle();
      @(negedge clk);
      while (m_busy || m_done) @(negedge clk);
   endtask

   task automatic go(input logic [63:0] r, input logic [31:0] b, input string tag);
      cur_tag = tag;
      rate_bps = r; burst_bytes = b; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_idle();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: values held in reset
      cur_tag = "R1";
      chk("R1 reset busy", 64'(busy), 0);
      chk("R1 reset done", 64'(done), 0);
      chk("R1 reset fields", 64'({rate_mant, rate_exp, rate_div, burst_mant, burst_exp}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 after release", 64'({busy, done, rate_mant, rate_exp, rate_div, burst_mant, burst_exp}), 0);

      go(64'd4_000_000,      32'd300,        "R6 R4 window edge");
      go(64'd5_000_000,      32'd0,          "R6 R2 zero burst");
      go(64'd2_000_000,      32'd255,        "R7 R3 one doubling");
      go(64'd3_999_999,      32'd256,        "R7 R4 near top");
      go(64'd8_000_000,      32'd8_388_607,  "R8 R4 one halving");
      go(64'd1_000_000_000,  32'd1_000_000,  "R8 R4 gigabit");
      go(64'd100_000_000_000, 32'd8_388_608, "R8 R5 clamp burst");
      go('1,                 32'hFFFF_FFFF,  "R9 R5 saturate");
      go(64'd0,              32'd1,          "R10 zero rate");
      go(64'd1,              32'd7,          "R10 R3 tiny rate");

      // R12: start while busy must be ignored
      cur_tag = "R12 ignore";
      rate_bps = 64'd0; burst_bytes = 32'd300; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (4) @(negedge clk);
      rate_bps = 64'd5_000_000; burst_bytes = 32'd70_000; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_idle();
      chk("R12 ignored rate_div", 64'(rate_div), 64'd15);
      chk("R12 ignored burst_exp", 64'(burst_exp), 64'd8);

      // R12 R11: start held high, accepted in each done cycle
      cur_tag = "R12 R11 back-to-back";
      rate_bps = 64'd2_000_000; burst_bytes = 32'd500; start = 1'b1;
      repeat (9) @(negedge clk);
      start = 1'b0;
      wait_idle();
      repeat (3) @(negedge clk);

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule